// File: doc/BRIEF.md
# Stack-CPU Instruction Payload Sequencer

This block sits between instruction memory and the execute stage of a small stack processor. Every instruction word is a fixed 16-bit payload. A one- or two-bit prefix selects how the remaining bits are packed: three 5-bit primitive operations, two 7-bit full opcodes, or one 4-bit immediate-operation code with a 10-bit operand. The sequencer fetches payloads and splits them into their operations. It hands those operations to execute one per cycle, with a kind tag that execute uses to interpret the code and operand fields.

The memory path is either 16 bits wide (parameter `BUS_W` = 16) or byte-wide (`BUS_W` = 8). On the byte path the payload arrives high byte first. The high byte carries the whole format prefix, so a primitive-format payload issues its first operation in the same cycle that byte arrives. Memory returns data in the cycle that `fetch_req` and `mem_valid` are both high. Execute can ask the sequencer to skip forward. A taken branch flushes the sequencer and restarts fetch at a new byte address.

Top module: `psq_payload_seq`

## Requirements
- R1: A payload with bit 15 = 1 issues three operations of kind PRIM (code 0), taken from bits [14:10], [9:5] and [4:0] in that order, one per cycle.
- R2: A payload with bits [15:14] = 00 issues two operations of kind STD (code 1), taken from bits [13:7] and then [6:0].
- R3: A payload with bits [15:14] = 01 issues one operation of kind IMM (code 2). `op_code[3:0]` carries bits [13:10] and `op_arg` carries bits [9:0].
- R4: With BUS_W = 16, the first operation of a payload is issued in the same cycle the payload is accepted. Each accepted transfer advances `fetch_addr` by 2.
- R5: With BUS_W = 8, the high byte (even address) is fetched before the low byte and each accepted byte advances `fetch_addr` by 1. A PRIM payload issues its first operation in the cycle its high byte is accepted.
- R6: With BUS_W = 8, STD and IMM payloads issue nothing on the high byte. They issue their first operation in the cycle the low byte is accepted.
- R7: `fetch_req` is low while operations of the current payload are still waiting to issue. It rises in the cycle after the last one issues.
- R8: A PRIM code is zero-extended into the 7-bit `op_code`, so it equals the full opcode of the same value. `op_arg` is zero for every kind except IMM.
- R9: In a cycle with `skip` high, no operation issues and no fetch is requested. The remaining operations of the current payload are dropped, and the next fetch starts 6 bytes past that payload's start address, which passes over the two payloads that follow it.
- R10: In a cycle with `flush` high, no operation issues and no fetch is requested. All pending operations and any half-received payload are dropped, and `fetch_addr` equals `flush_addr` in the next cycle. Flush takes priority over skip.
- R11: During and right after reset, `fetch_addr` is `RESET_ADDR` (0), `fetch_req` is high and `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | output | 1 | Request for the next memory transfer |
| fetch_addr | output | AW | Byte address of the requested transfer |
| mem_valid | input | 1 | Memory returns data this cycle |
| mem_data | input | BUS_W | Returned byte or payload |
| op_valid | output | 1 | An operation is issued this cycle |
| op_kind | output | 2 | 0 PRIM, 1 STD, 2 IMM |
| op_code | output | 7 | Operation code, zero-extended |
| op_arg | output | 10 | Immediate operand (IMM only) |
| skip | input | 1 | Skip request from execute |
| flush | input | 1 | Taken-branch flush |
| flush_addr | input | AW | Restart byte address for a flush |

## Verification
The bench drives a 16-bit and a byte-wide instance side by side. It checks the cycle-exact issue and request pattern over a primitive, an opcode-pair and an immediate payload. A design that waited for the low byte before issuing a primitive, or that issued something on the high byte of an opcode pair, would shift that pattern by a cycle. Random memory stalls, skips placed right after an issue, and flushes that land between the two bytes of a payload are checked against an independent walk of the operation stream. Decoding a slot from the wrong bit range, keeping a stale high byte after a flush, or jumping to the wrong skip target shows up there as a mismatched operation or address.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [1:0] {
        KIND_PRIM = 2'd0,
        KIND_STD  = 2'd1,
        KIND_IMM  = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [6:0]  code;
        logic [9:0]  arg;
    } op_t;

    // payloads passed over on a skip, after the current one
    localparam int SKIP_PAYLOADS = 2;
    localparam int PAYLOAD_BYTES = 2;

    function automatic op_kind_e fmt_of(input logic [15:0] w);
        if (w[15])      return KIND_PRIM;
        else if (w[14]) return KIND_IMM;
        else            return KIND_STD;
    endfunction

    function automatic logic [1:0] slot_count(input op_kind_e k);
        case (k)
            KIND_PRIM: return 2'd3;
            KIND_STD:  return 2'd2;
            default:   return 2'd1;
        endcase
    endfunction

    function automatic op_t slot_op(input logic [15:0] w, input logic [1:0] idx);
        op_t o;
        o      = '0;
        o.kind = fmt_of(w);
        case (o.kind)
            KIND_PRIM: begin
                case (idx)
                    2'd0:    o.code = {2'b00, w[14:10]};
                    2'd1:    o.code = {2'b00, w[9:5]};
                    default: o.code = {2'b00, w[4:0]};
                endcase
            end
            KIND_STD:  o.code = (idx == 2'd0) ? w[13:7] : w[6:0];
            default: begin
                o.code = {3'b000, w[13:10]};
                o.arg  = w[9:0];
            end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/psq_assemble.sv
module psq_assemble #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [BUS_W-1:0] bus,
    output logic [15:0]      word,
    output logic             completes,
    output logic             half
);
    localparam bit NARROW = (BUS_W == 8);

    logic hi_q;

    // high byte held on the narrow path; always clear on the wide path
    always_ff @(posedge clk) begin
        if (rst || clear)
            hi_q <= 1'b0;
        else if (take)
            hi_q <= NARROW ? !hi_q : 1'b0;
    end

    assign half = hi_q;

    generate
        if (NARROW) begin : g_byte
            logic [7:0] hi_byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    hi_byte_q <= '0;
                else if (take && !hi_q)
                    hi_byte_q <= bus[7:0];
            end
            assign word      = hi_q ? {hi_byte_q, bus[7:0]} : {bus[7:0], 8'h00};
            assign completes = hi_q;
        end else begin : g_word
            assign word      = bus[15:0];
            assign completes = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/psq_slot_queue.sv
module psq_slot_queue
    import psq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        load,
    input  logic [15:0] load_word,
    input  logic [1:0]  load_idx,
    input  logic [1:0]  load_cnt,
    input  logic        pop,
    output logic        busy,
    output op_t         head
);
    logic [15:0] pay_q;
    logic [1:0]  nxt_q;
    logic [1:0]  pend_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pay_q  <= '0;
            nxt_q  <= '0;
            pend_q <= '0;
        end else if (load) begin
            pay_q  <= load_word;
            nxt_q  <= load_idx;
            pend_q <= load_cnt;
        end else if (pop) begin
            nxt_q  <= nxt_q + 2'd1;
            pend_q <= pend_q - 2'd1;
        end
    end

    assign busy = (pend_q != 2'd0);
    assign head = slot_op(pay_q, nxt_q);
endmodule

// File: rtl/psq_fetch_addr.sv
module psq_fetch_addr #(
    parameter int AW         = 16,
    parameter int STEP       = 2,
    parameter int RESET_ADDR = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          skip,
    input  logic          advance,
    input  logic          mark,
    output logic [AW-1:0] addr
);
    localparam int            SKIP_BYTES = psq_pkg::PAYLOAD_BYTES * (1 + psq_pkg::SKIP_PAYLOADS);
    localparam logic [AW-1:0] SKIP_INC   = AW'(SKIP_BYTES);
    localparam logic [AW-1:0] STEP_INC   = AW'(STEP);
    localparam logic [AW-1:0] RST_VAL    = AW'(RESET_ADDR);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= RST_VAL;
            base_q <= RST_VAL;
        end else if (flush) begin
            addr_q <= flush_addr;
        end else if (skip) begin
            addr_q <= base_q + SKIP_INC;
        end else if (advance) begin
            addr_q <= addr_q + STEP_INC;
            if (mark)
                base_q <= addr_q;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/psq_payload_seq.sv
module psq_payload_seq
    import psq_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int AW         = 16,
    parameter int RESET_ADDR = 0
) (
    input  logic             clk,
    input  logic             rst,
    output logic             fetch_req,
    output logic [AW-1:0]    fetch_addr,
    input  logic             mem_valid,
    input  logic [BUS_W-1:0] mem_data,
    output logic             op_valid,
    output logic [1:0]       op_kind,
    output logic [6:0]       op_code,
    output logic [9:0]       op_arg,
    input  logic             skip,
    input  logic             flush,
    input  logic [AW-1:0]    flush_addr
);
    localparam int STEP = BUS_W / 8;

    logic        hold;
    logic        take;
    logic        q_busy;
    op_t         q_head;
    logic [15:0] asm_word;
    logic        asm_done;
    logic        asm_half;
    op_kind_e    fmt;
    logic [1:0]  first_idx;
    logic [1:0]  remain;
    logic        live_issue;
    op_t         live_op;
    logic        ld;
    logic        pop;
    op_t         out_op;

    assign hold      = flush | skip;
    assign fetch_req = !q_busy && !hold;
    assign take      = fetch_req && mem_valid;

    psq_assemble #(.BUS_W(BUS_W)) asm_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (hold),
        .take      (take),
        .bus       (mem_data),
        .word      (asm_word),
        .completes (asm_done),
        .half      (asm_half)
    );

    always_comb begin
        fmt        = fmt_of(asm_word);
        first_idx  = (asm_half && fmt == KIND_PRIM) ? 2'd1 : 2'd0;
        remain     = slot_count(fmt) - first_idx - 2'd1;
        live_issue = 1'b0;
        ld         = 1'b0;
        live_op    = slot_op(asm_word, first_idx);
        if (take) begin
            if (asm_done) begin
                live_issue = 1'b1;
                ld         = (remain != 2'd0);
            end else begin
                live_issue = (fmt == KIND_PRIM);
            end
        end
    end

    assign pop = q_busy && !hold;

    psq_slot_queue q_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (hold),
        .load      (ld),
        .load_word (asm_word),
        .load_idx  (first_idx + 2'd1),
        .load_cnt  (remain),
        .pop       (pop),
        .busy      (q_busy),
        .head      (q_head)
    );

    psq_fetch_addr #(.AW(AW), .STEP(STEP), .RESET_ADDR(RESET_ADDR)) fa_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .flush_addr (flush_addr),
        .skip       (skip),
        .advance    (take),
        .mark       (!asm_half),
        .addr       (fetch_addr)
    );

    assign out_op   = pop ? q_head : live_op;
    assign op_valid = pop | live_issue;
    assign op_kind  = op_valid ? out_op.kind : 2'd0;
    assign op_code  = op_valid ? out_op.code : 7'd0;
    assign op_arg   = op_valid ? out_op.arg  : 10'd0;
endmodule

// File: rtl/psq_payload_seq_chk.sv
module psq_payload_seq_chk #(
    parameter int BUS_W = 16,
    parameter int AW    = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic          mem_valid,
    input logic          op_valid,
    input logic [1:0]    op_kind,
    input logic [6:0]    op_code,
    input logic [9:0]    op_arg,
    input logic          skip,
    input logic          flush,
    input logic [AW-1:0] flush_addr
);
    localparam logic [AW-1:0] STEP_INC = AW'(BUS_W / 8);

    a_r10_flush_target: assert property (@(posedge clk) disable iff (rst)
        flush |=> fetch_addr == $past(flush_addr));

    a_r10_flush_silent: assert property (@(posedge clk) disable iff (rst)
        flush |-> !op_valid && !fetch_req);

    a_r9_skip_silent: assert property (@(posedge clk) disable iff (rst)
        skip |-> !op_valid && !fetch_req);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && mem_valid && !flush && !skip) |=> fetch_addr == $past(fetch_addr) + STEP_INC);

    a_r8_prim_narrow: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd0) |-> op_code[6:5] == 2'b00);

    a_r8_arg_zero: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind != 2'd2) |-> op_arg == 10'd0);

    a_r3_imm_code: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd2) |-> op_code[6:4] == 3'b000);

    a_r1_kind_legal: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> op_kind != 2'd3);
endmodule

bind psq_payload_seq psq_payload_seq_chk #(.BUS_W(BUS_W), .AW(AW)) chk_i (.*);

// File: tb/psq_payload_seq_tb_top.sv
module psq_payload_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [15:0] pay [64];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        mv [2];
    logic        sk [2];
    logic        fl [2];
    logic [15:0] fla [2];
    logic        req [2];
    logic [15:0] fa [2];
    logic        ov [2];
    logic [1:0]  ok [2];
    logic [6:0]  oc [2];
    logic [9:0]  oa [2];
    logic [15:0] md16;
    logic [7:0]  md8;

    assign md16 = pay[fa[0][6:1]];
    assign md8  = fa[1][0] ? pay[fa[1][6:1]][7:0] : pay[fa[1][6:1]][15:8];

    psq_payload_seq #(.BUS_W(16)) dut_i (
        .clk(clk), .rst(rst), .fetch_req(req[0]), .fetch_addr(fa[0]),
        .mem_valid(mv[0]), .mem_data(md16), .op_valid(ov[0]), .op_kind(ok[0]),
        .op_code(oc[0]), .op_arg(oa[0]), .skip(sk[0]), .flush(fl[0]), .flush_addr(fla[0]));

    psq_payload_seq #(.BUS_W(8)) dut_b_i (
        .clk(clk), .rst(rst), .fetch_req(req[1]), .fetch_addr(fa[1]),
        .mem_valid(mv[1]), .mem_data(md8), .op_valid(ov[1]), .op_kind(ok[1]),
        .op_code(oc[1]), .op_arg(oa[1]), .skip(sk[1]), .flush(fl[1]), .flush_addr(fla[1]));

    // bench reference: kind(2) code(7) arg(10)
    function automatic logic [18:0] exp_op(input logic [15:0] w, input int slot);
        if (w[15] == 1'b1) begin
            if (slot == 0) return {2'd0, 2'b00, w[14:10], 10'd0};
            if (slot == 1) return {2'd0, 2'b00, w[9:5], 10'd0};
            return {2'd0, 2'b00, w[4:0], 10'd0};
        end
        if (w[14] == 1'b0) return (slot == 0) ? {2'd1, w[13:7], 10'd0} : {2'd1, w[6:0], 10'd0};
        return {2'd2, 3'b000, w[13:10], w[9:0]};
    endfunction

    function automatic int exp_cnt(input logic [15:0] w);
        if (w[15]) return 3;
        return w[14] ? 1 : 2;
    endfunction

    task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    logic [15:0] ref_addr [2];
    int          ref_slot [2];
    logic [15:0] last_base [2];
    bit          skip_next [2];
    bit          addr_chk [2];
    logic [15:0] addr_exp [2];

    // cycle patterns, bit i = cycle i after reset release
    localparam logic [7:0] OV16  = 8'b0011_1111;
    localparam logic [7:0] RQ16  = 8'b0010_1001;
    localparam logic [7:0] OV8   = 8'b1011_0111;
    localparam logic [7:0] RQ8   = 8'b1101_1011;

    task automatic one_cycle(input bit rnd, input int cyc);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            sk[d] = skip_next[d];
            fl[d] = 1'b0;
            if (rnd) begin
                mv[d] = ($urandom % 4) != 0;
                if (!skip_next[d] && ($urandom % 48) == 0) begin
                    fl[d]  = 1'b1;
                    fla[d] = 16'(($urandom % 64) * 2);
                end
            end else begin
                mv[d] = 1'b1;
            end
        end
        #2;
        for (int d = 0; d < 2; d++) begin
            string tg;
            logic [18:0] e;
            if (addr_chk[d]) begin
                tg = (addr_exp[d] == ref_addr[d] && fl[d] == 1'b0) ? "R9/R10 jump target" : "R10 jump target";
                chk(fa[d] == addr_exp[d], tg, 32'(fa[d]), 32'(addr_exp[d]));
                addr_chk[d] = 1'b0;
            end
            if (!rnd) begin
                if (d == 0 && cyc < 6) begin
                    chk(ov[d] == OV16[cyc], "R4 issue timing 16-bit", 32'(ov[d]), 32'(OV16[cyc]));
                    chk(req[d] == RQ16[cyc], "R7 fetch request 16-bit", 32'(req[d]), 32'(RQ16[cyc]));
                end
                if (d == 1) begin
                    chk(ov[d] == OV8[cyc], (cyc < 3) ? "R5 early issue 8-bit" : "R6 issue timing 8-bit",
                        32'(ov[d]), 32'(OV8[cyc]));
                    chk(req[d] == RQ8[cyc], "R7 fetch request 8-bit", 32'(req[d]), 32'(RQ8[cyc]));
                    if (cyc == 1)
                        chk(fa[d] == 16'd1, "R5 low byte address", 32'(fa[d]), 32'd1);
                end
            end
            if (sk[d]) begin
                chk(ov[d] == 1'b0 && req[d] == 1'b0, "R9 silent skip cycle", 32'({ov[d], req[d]}), 32'd0);
                ref_addr[d] = last_base[d] + 16'd6;
                ref_slot[d] = 0;
                addr_chk[d] = 1'b1;
                addr_exp[d] = ref_addr[d];
            end else if (fl[d]) begin
                chk(ov[d] == 1'b0 && req[d] == 1'b0, "R10 silent flush cycle", 32'({ov[d], req[d]}), 32'd0);
                ref_addr[d] = fla[d];
                ref_slot[d] = 0;
                addr_chk[d] = 1'b1;
                addr_exp[d] = fla[d];
            end else if (ov[d]) begin
                e = exp_op(pay[ref_addr[d][6:1]], ref_slot[d]);
                tg = (e[18:17] == 2'd0) ? "R1 R8 primitive op" :
                     (e[18:17] == 2'd1) ? "R2 R8 opcode pair op" : "R3 immediate op";
                chk({ok[d], oc[d], oa[d]} == e, tg, 32'({ok[d], oc[d], oa[d]}), 32'(e));
                last_base[d] = ref_addr[d];
                ref_slot[d]++;
                if (ref_slot[d] >= exp_cnt(pay[ref_addr[d][6:1]])) begin
                    ref_slot[d] = 0;
                    ref_addr[d] = ref_addr[d] + 16'd2;
                end
            end
            skip_next[d] = rnd && ov[d] && !sk[d] && !fl[d] && (($urandom % 6) == 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) pay[i] = 16'($urandom);
        pay[0] = 16'h8443;  // prim 1,2,3
        pay[1] = 16'h02FF;  // std 5,127
        pay[2] = 16'h6AA5;  // imm 10, arg 0x2A5
        for (int d = 0; d < 2; d++) begin
            mv[d] = 1'b0; sk[d] = 1'b0; fl[d] = 1'b0; fla[d] = '0;
            ref_addr[d] = '0; ref_slot[d] = 0; last_base[d] = '0;
            skip_next[d] = 1'b0; addr_chk[d] = 1'b0; addr_exp[d] = '0;
        end
        repeat (3) @(negedge clk);
        #2;
        for (int d = 0; d < 2; d++) begin
            chk(req[d] == 1'b1 && ov[d] == 1'b0, "R11 reset outputs", 32'({req[d], ov[d]}), 32'h2);
            chk(fa[d] == 16'd0, "R11 reset address", 32'(fa[d]), 32'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 8; c++) one_cycle(1'b0, c);
        for (int c = 0; c < 5000; c++) one_cycle(1'b1, c);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule